// File: doc/BRIEF.md
# Four-Decade Decimal Up/Down Counter

This block is a decimal counter of four BCD decades covering 0000 to 9999. It takes an asynchronous count pulse and brings it into the system clock domain. Each rising edge of that pulse moves the count by one step, up or down as the direction input selects. The count wraps at both ends, and each wrap raises a one-cycle carry/borrow pulse. A flag reports when all four decades are zero.

A separate output latch holds the value that is shown. It follows the live count while the active-low store input is low and holds while that input is high. A load controller presets single decades of either the counter or a companion holding register through a digit strobe and a 4-bit BCD data bus. An active-low clear input zeroes the count. If a register load is strobed while clear is low, the strobed register digits load zero. Count edges are ignored while clear or any load is active.

Top module: `bcd_updown_counter`

## Requirements
- R1: With `up` high, each rising edge of `cnt_in` adds one to the decimal count, and the carry ripples between decades (0009 to 0010, 0099 to 0100).
- R2: With `up` low, each rising edge of `cnt_in` subtracts one, and the borrow ripples between decades (0100 to 0099).
- R3: Counting up from 9999 gives 0000 and counting down from 0000 gives 9999. Each wrap drives `carry` high for exactly one clock cycle, and no other step raises it.
- R4: While `clr_n` is low, the count is held at 0000 and `cnt_in` edges have no effect. A clear with no register load leaves `reg_q` unchanged.
- R5: While `ld_cnt` or `ld_reg` is high, `cnt_in` edges do not change the count, even when no digit is strobed.
- R6: With `ld_cnt` high, each bit i of `ld_dig` that is high loads `ld_data` into counter decade i (bits 4i+3..4i, decade 0 least significant). Other decades keep their value.
- R7: With `ld_reg` high, each bit i of `ld_dig` that is high loads `ld_data` into bits 4i+3..4i of `reg_q`, and the count is not disturbed.
- R8: A register load strobed while `clr_n` is low writes 0 into the strobed register decades, whatever `ld_data` holds.
- R9: While `store_n` is low, `disp_q` takes the live count one cycle later. While `store_n` is high, `disp_q` holds.
- R10: `zero` is high exactly when all four counter decades are 0.
- R11: After the synchronous reset `rst`, the count, `disp_q` and `reg_q` are all 0, `carry` is low and `zero` is high.
- R12: A rising edge of `cnt_in` counts once, however long `cnt_in` then stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_in | input | 1 | Asynchronous count pulse; rising edges count |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| store_n | input | 1 | Active-low: output latch follows the count |
| clr_n | input | 1 | Active-low clear of the count |
| ld_cnt | input | 1 | Counter preset active |
| ld_reg | input | 1 | Holding-register preset active |
| ld_dig | input | 4 | Per-decade load strobe, bit 0 = least significant decade |
| ld_data | input | 4 | BCD preset data |
| disp_q | output | 16 | Latched BCD value, four decades |
| reg_q | output | 16 | Holding-register contents |
| carry | output | 1 | One-cycle pulse on a wrap in either direction |
| zero | output | 1 | Live count equals 0000 |

## Verification
The case that needs the most care is a count edge arriving in the same cycle as a clear or a preset. The counter must then give priority to the clear or the load and drop the step. The bench holds `clr_n` low, or raises `ld_cnt` or `ld_reg` with and without a digit strobe, across a complete `cnt_in` pulse. It then checks that the latched value equals the cleared or preset value and has no extra step. It also checks that `carry` stays low. A long up and down sweep of more than 1200 steps, together with wrap runs at both ends, compares every step against an arithmetic decimal model.

// File: rtl/bcdctr_pkg.sv
package bcdctr_pkg;
  typedef logic [3:0] bcd_t;

  function automatic bcd_t bcd_inc(bcd_t d);
    return (d >= 4'd9) ? 4'd0 : 4'(d + 4'd1);
  endfunction

  function automatic bcd_t bcd_dec(bcd_t d);
    return (d == 4'd0 || d > 4'd9) ? 4'd9 : 4'(d - 4'd1);
  endfunction
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~last;

  // R12: a detected edge never repeats in the next cycle
  a_r12_single_rise: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade
  import bcdctr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  input  logic up,
  input  logic load,
  input  bcd_t ld_val,
  output bcd_t q,
  output logic at_max,
  output logic at_min
);
  always_ff @(posedge clk) begin
    if (rst || clr)  q <= '0;
    else if (load)   q <= ld_val;
    else if (step)   q <= up ? bcd_inc(q) : bcd_dec(q);
  end

  assign at_max = (q == 4'd9);
  assign at_min = (q == 4'd0);

  // R1: an up step below 9 adds one
  a_r1_up_step: assert property (@(posedge clk) disable iff (rst)
    (step && up && !clr && !load && q < 4'd9) |=> q == 4'($past(q) + 4'd1));
  // R2: a down step above 0 subtracts one
  a_r2_down_step: assert property (@(posedge clk) disable iff (rst)
    (step && !up && !clr && !load && q > 4'd0 && q <= 4'd9) |=> q == 4'($past(q) - 4'd1));
endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
  import bcdctr_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cnt_in,
  input  logic                up,
  input  logic                store_n,
  input  logic                clr_n,
  input  logic                ld_cnt,
  input  logic                ld_reg,
  input  logic [DIGITS-1:0]   ld_dig,
  input  logic [3:0]          ld_data,
  output logic [4*DIGITS-1:0] disp_q,
  output logic [4*DIGITS-1:0] reg_q,
  output logic                carry,
  output logic                zero
);
  localparam int W = 4 * DIGITS;

  logic            rise, step;
  logic [DIGITS:0] en;
  logic [DIGITS-1:0] d_max, d_min;
  logic [W-1:0]    live;
  bcd_t            ld_eff;

  edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(cnt_in), .rise(rise)
  );

  assign step   = rise & clr_n & ~ld_cnt & ~ld_reg;
  assign ld_eff = clr_n ? ld_data : 4'd0;
  assign en[0]  = step;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dec
    bcd_t q;
    bcd_decade u_dec (
      .clk(clk), .rst(rst), .clr(~clr_n), .step(en[i]), .up(up),
      .load(ld_cnt & ld_dig[i]), .ld_val(ld_eff),
      .q(q), .at_max(d_max[i]), .at_min(d_min[i])
    );
    assign live[4*i +: 4] = q;
    assign en[i+1] = en[i] & (up ? d_max[i] : d_min[i]);

    always_ff @(posedge clk) begin
      if (rst)                      reg_q[4*i +: 4] <= '0;
      else if (ld_reg && ld_dig[i]) reg_q[4*i +: 4] <= ld_eff;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carry  <= 1'b0;
      disp_q <= '0;
    end else begin
      carry <= en[DIGITS];
      if (!store_n) disp_q <= live;
    end
  end

  assign zero = (live == '0);

  // R4: clear forces the live count to zero
  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> live == '0);
  // R5: an edge during a load with no strobe leaves the count alone
  a_r5_inhibit: assert property (@(posedge clk) disable iff (rst)
    (rise && clr_n && (ld_cnt || ld_reg) && ld_dig == '0) |=> $stable(live));
  // R3: the wrap pulse lasts one cycle
  a_r3_carry_pulse: assert property (@(posedge clk) disable iff (rst)
    carry |=> !carry);
  // R9: with store high the latch holds
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    store_n |=> $stable(disp_q));
endmodule

// File: tb/bcd_updown_counter_test.sv
module bcd_updown_counter_test;
  logic clk = 0, rst = 1, cnt_in = 0, up = 1, store_n = 0, clr_n = 1;
  logic ld_cnt = 0, ld_reg = 0;
  logic [3:0] ld_dig = 0, ld_data = 0;
  logic [15:0] disp_q, reg_q;
  logic carry, zero;
  int errors = 0, checks = 0, ref_cnt = 0, ref_reg = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bcd_updown_counter uut (
    .clk(clk), .rst(rst), .cnt_in(cnt_in), .up(up), .store_n(store_n),
    .clr_n(clr_n), .ld_cnt(ld_cnt), .ld_reg(ld_reg), .ld_dig(ld_dig),
    .ld_data(ld_data), .disp_q(disp_q), .reg_q(reg_q), .carry(carry), .zero(zero)
  );

  function automatic logic [15:0] to_bcd(int v);
    logic [15:0] r;
    int x = v;
    for (int k = 0; k < 4; k++) begin
      r[4*k +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cnt_in pulse held several clocks; returns number of carry cycles seen
  task automatic pulse(output int ncar, input int hold = 4);
    ncar = 0;
    cnt_in = 1;
    repeat (hold) begin @(negedge clk); if (carry) ncar++; end
    cnt_in = 0;
    repeat (4) begin @(negedge clk); if (carry) ncar++; end
  endtask

  task automatic step_chk(string req);
    int nc;
    bit wrap;
    pulse(nc);
    wrap = up ? (ref_cnt == 9999) : (ref_cnt == 0);
    ref_cnt = up ? (ref_cnt + 1) % 10000 : (ref_cnt + 9999) % 10000;
    chk(req, disp_q, to_bcd(ref_cnt));
    chk("R3", nc, wrap ? 1 : 0);
  endtask

  task automatic preset(bit to_reg, int v);
    logic [15:0] b = to_bcd(v);
    @(negedge clk);
    if (to_reg) ld_reg = 1; else ld_cnt = 1;
    for (int i = 0; i < 4; i++) begin
      ld_dig = 4'(1 << i);
      ld_data = b[4*i +: 4];
      @(negedge clk);
    end
    ld_dig = 0; ld_cnt = 0; ld_reg = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int nc;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk("R11", disp_q, 0); chk("R11", reg_q, 0);
    chk("R11", carry, 0);  chk("R11", zero, 1);

    // R1 long up sweep, R12 long hold
    up = 1;
    for (int n = 0; n < 1205; n++) step_chk(n % 2 ? "R1" : "R12");
    pulse(nc, 20); ref_cnt++;
    chk("R12", disp_q, to_bcd(ref_cnt));
    // R2 down sweep through zero
    up = 0;
    for (int n = 0; n < 1220; n++) step_chk("R2");
    // R3 up wrap
    preset(0, 9990); ref_cnt = 9990;
    chk("R6", disp_q, to_bcd(9990)); chk("R10", zero, 0);
    up = 1;
    for (int n = 0; n < 15; n++) step_chk("R3");
    // R10 zero flag
    preset(0, 1); ref_cnt = 1; up = 0;
    step_chk("R2"); chk("R10", zero, 1);
    step_chk("R3"); chk("R10", zero, 0);

    // R6 single-digit preset, others untouched
    preset(0, 4321); ref_cnt = 4321;
    @(negedge clk); ld_cnt = 1; ld_dig = 4'b0100; ld_data = 4'd7;
    @(negedge clk); ld_cnt = 0; ld_dig = 0; repeat (2) @(negedge clk);
    ref_cnt = 4721; chk("R6", disp_q, to_bcd(ref_cnt));

    // R7 register preset leaves counter
    preset(1, 1234); ref_reg = 1234;
    chk("R7", reg_q, to_bcd(1234)); chk("R7", disp_q, to_bcd(ref_cnt));

    // R5 load active, no strobe, edge ignored
    ld_cnt = 1; pulse(nc); ld_cnt = 0;
    chk("R5", disp_q, to_bcd(ref_cnt)); chk("R5", nc, 0);
    ld_reg = 1; pulse(nc); ld_reg = 0;
    chk("R5", disp_q, to_bcd(ref_cnt));
    // R5 edge coinciding with strobed load: load wins, no step
    ld_cnt = 1; ld_dig = 4'b0001; ld_data = 4'd3;
    pulse(nc); ld_cnt = 0; ld_dig = 0;
    ref_cnt = 4723; chk("R5", disp_q, to_bcd(ref_cnt));

    // R9 store hold
    store_n = 1; up = 1;
    pulse(nc); pulse(nc);
    chk("R9", disp_q, to_bcd(ref_cnt));
    ref_cnt += 2;
    store_n = 0; repeat (2) @(negedge clk);
    chk("R9", disp_q, to_bcd(ref_cnt));

    // R4 clear with edge, register untouched
    clr_n = 0; pulse(nc);
    chk("R4", disp_q, 0); chk("R4", zero, 1); chk("R4", reg_q, to_bcd(ref_reg));
    // R8 register load during clear
    ld_reg = 1; ld_dig = 4'b1010; ld_data = 4'd5; @(negedge clk);
    ld_reg = 0; ld_dig = 0; clr_n = 1; repeat (2) @(negedge clk);
    chk("R8", reg_q, to_bcd(0204));
    ref_cnt = 0; up = 1; step_chk("R1");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule